// File: doc/BRIEF.md
# Line-Rate Video Presence Detector

This block decides whether a usable video signal is feeding a sync separator. It receives one strobe per accepted horizontal line and times the gap between strobes with a counter running on the system clock. Gaps inside the legal line-period window count as valid lines. Gaps that are too short, and silences longer than the window, count as invalid lines. From this stream of verdicts a three-state controller drives a mute flag that the downstream sync outputs use to force themselves to logic high.

The controller has three states. MUTED is entered from reset and holds the mute flag high. VALID holds the mute flag low. PROBATION is a grace interval after a fault in which the outputs stay live. The transitions are: MUTED to VALID (lock) after eight back-to-back valid lines; VALID to PROBATION (fault) on any invalid line; PROBATION to VALID (recover) when eight back-to-back valid lines complete before the grace interval ends; PROBATION to MUTED (expire) when the grace interval runs out first. Lock has priority over expire when both fall on the same cycle. The line-period window and the grace interval are given in hertz and microseconds and turned into cycle counts from the clock frequency parameter.

Top module: `vpd_presence_detector`

## Requirements
- R1: While reset is held and after it is released, with no strobes, `state` reads 0 (MUTED) and `mute` reads 1.
- R2: A strobe whose distance from the previous strobe is between PER_MIN = CLK_HZ/LINE_HZ_MAX and PER_MAX = CLK_HZ/LINE_HZ_MIN cycles, both ends included, is a valid line. The first strobe after reset or after a silence timeout only starts the measurement and gives no verdict.
- R3: A strobe closer than PER_MIN cycles to the previous one is an invalid line. PER_MAX cycles after the last strobe with no new strobe also make an invalid line, and the next strobe then only restarts the measurement.
- R4: An invalid line resets the run of consecutive valid lines to zero, so eight fresh valid lines are needed after it.
- R5: In MUTED (code 0), the eighth consecutive valid line moves `state` to VALID (code 1) on the clock edge after the edge that sampled that strobe. Seven lines leave the state at MUTED.
- R6: In VALID, an invalid line moves `state` to PROBATION (code 2) one edge after the verdict. `mute` stays 0 for the whole time spent in PROBATION.
- R7: In PROBATION, the eighth consecutive valid line returns `state` to VALID with the same latency as in R5, and `mute` never rises.
- R8: If PROBATION is entered at edge p and no recovery occurs, `state` becomes MUTED at edge p + PROB_CYC, where PROB_CYC = (CLK_HZ/1e6)·PROB_US. It is still PROBATION one edge earlier.
- R9: `mute` is a register that equals 1 exactly one edge after `state` has been MUTED. It changes only on the clock edge that follows a change of state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_stb | input | 1 | One-cycle pulse per accepted horizontal line |
| mute | output | 1 | 1 forces the sync outputs high |
| state | output | 2 | 0 MUTED, 1 VALID, 2 PROBATION |

## Verification
The edge that samples a strobe registers the line verdict. The state moves on the next edge, and mute follows one edge after that. A silence verdict lands PER_MAX edges after the last strobe, and expiry lands PROB_CYC edges after probation begins. The driver places each strobe on a known edge number and queues every expected state or mute value with the exact edge it is due on. The monitor compares on the falling edge of that cycle, so each value is read between edges and never at the edge where it changes. Boundary gaps of exactly PER_MIN and PER_MAX, one cycle outside them, a seven-line run, an interrupted run and an expiry during a partial recovery are each queued with their own due edges.

// File: rtl/vpd_pkg.sv
package vpd_pkg;
    typedef enum logic [1:0] {
        ST_MUTED = 2'd0,
        ST_VALID = 2'd1,
        ST_PROB  = 2'd2
    } vpd_state_e;
endpackage

// File: rtl/vpd_period_meter.sv
module vpd_period_meter #(
    parameter int unsigned PER_MIN = 50,
    parameter int unsigned PER_MAX = 85
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_stb,
    output logic line_good,
    output logic line_bad
);
    localparam int CW = $clog2(PER_MAX + 1);

    logic [CW-1:0] cnt_q;
    logic          armed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            armed_q   <= 1'b0;
            line_good <= 1'b0;
            line_bad  <= 1'b0;
        end else begin
            line_good <= 1'b0;
            line_bad  <= 1'b0;
            if (line_stb) begin
                if (armed_q) begin
                    if (cnt_q >= CW'(PER_MIN)) line_good <= 1'b1;
                    else                       line_bad  <= 1'b1;
                end
                cnt_q   <= CW'(1);
                armed_q <= 1'b1;
            end else if (armed_q) begin
                if (cnt_q == CW'(PER_MAX)) begin
                    line_bad <= 1'b1;
                    armed_q  <= 1'b0;
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                end
            end
        end
    end

    // R2/R3: a verdict is never both good and bad
    p_one_verdict_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({line_good, line_bad}));

    // R3: the gap counter never runs past the window
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(PER_MAX));
endmodule

// File: rtl/vpd_run_counter.sv
module vpd_run_counter #(
    parameter int unsigned LOCK_LINES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_good,
    input  logic line_bad,
    input  logic clr,
    output logic lock_now
);
    localparam int RW = $clog2(LOCK_LINES + 1);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (clr || line_bad) begin
            run_q <= '0;
        end else if (line_good && run_q != RW'(LOCK_LINES)) begin
            run_q <= run_q + RW'(1);
        end
    end

    assign lock_now = line_good && (run_q == RW'(LOCK_LINES - 1));

    p_run_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RW'(LOCK_LINES));

    p_bad_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        line_bad |=> (run_q == '0));
endmodule

// File: rtl/vpd_probation_timer.sv
module vpd_probation_timer #(
    parameter int unsigned PROB_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int PW = $clog2(PROB_CYC + 1);

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (!expired)  cnt_q <= cnt_q + PW'(1);
    end

    assign expired = run && (cnt_q == PW'(PROB_CYC - 1));

    p_timer_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < PW'(PROB_CYC));
endmodule

// File: rtl/vpd_presence_detector.sv
module vpd_presence_detector
    import vpd_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 125_000_000,
    parameter int unsigned LINE_HZ_MIN = 11_700,
    parameter int unsigned LINE_HZ_MAX = 19_700,
    parameter int unsigned PROB_US     = 2_500,
    parameter int unsigned LOCK_LINES  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_stb,
    output logic       mute,
    output logic [1:0] state
);
    localparam int unsigned PER_MIN  = CLK_HZ / LINE_HZ_MAX;
    localparam int unsigned PER_MAX  = CLK_HZ / LINE_HZ_MIN;
    localparam int unsigned PROB_CYC = (CLK_HZ / 1_000_000) * PROB_US;

    vpd_state_e state_q, state_d;
    logic line_good, line_bad, lock_now, expired, clr_run, mute_q;

    vpd_period_meter #(.PER_MIN(PER_MIN), .PER_MAX(PER_MAX)) u_meter (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb),
        .line_good(line_good), .line_bad(line_bad)
    );

    vpd_run_counter #(.LOCK_LINES(LOCK_LINES)) u_run (
        .clk(clk), .rst_n(rst_n), .line_good(line_good), .line_bad(line_bad),
        .clr(clr_run), .lock_now(lock_now)
    );

    vpd_probation_timer #(.PROB_CYC(PROB_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(state_q == ST_PROB), .expired(expired)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        clr_run = 1'b0;
        unique case (state_q)
            ST_MUTED: if (lock_now) state_d = ST_VALID;
            ST_VALID: if (line_bad) state_d = ST_PROB;
            ST_PROB: begin
                if (lock_now) begin
                    state_d = ST_VALID;
                end else if (expired) begin
                    state_d = ST_MUTED;
                    clr_run = 1'b1;
                end
            end
            default: state_d = ST_MUTED;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_MUTED;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) mute_q <= 1'b1;
        else        mute_q <= (state_q == ST_MUTED);
    end

    assign mute  = mute_q;
    assign state = state_q;

    p_live_probation_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROB) |-> !mute_q);

    p_enter_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_VALID) |-> $past(lock_now));

    p_expire_mutes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROB && expired && !lock_now) |=> (state_q == ST_MUTED));

    p_no_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MUTED) |=> (state_q != ST_PROB));

    p_mute_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mute_q) |-> ($past(state_q) == ST_MUTED));
endmodule

// File: tb/test_vpd_presence_detector.sv
module test_vpd_presence_detector;
    // Scaled clock figure so line periods stay short: PER_MIN=50,
    // PER_MAX=85, PROB_CYC=1000 cycles; the bench clock itself is 125 MHz.
    localparam int PMIN = 50;
    localparam int PMAX = 85;
    localparam int PROB = 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_stb = 1'b0;
    logic       mute;
    logic [1:0] state;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int last_edge = 0;

    typedef struct {
        int         due;
        bit         is_mute;
        logic [1:0] val;
        string      tag;
    } item_t;
    item_t sb[$];

    vpd_presence_detector #(
        .CLK_HZ(1_000_000), .LINE_HZ_MIN(11_700), .LINE_HZ_MAX(19_700),
        .PROB_US(1000), .LOCK_LINES(8)
    ) i_vpd_presence_detector (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .mute(mute), .state(state)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic expect_at(input int due, input bit is_mute, input int val, input string tag);
        item_t it;
        int i = 0;
        it.due = due; it.is_mute = is_mute; it.val = 2'(val); it.tag = tag;
        while (i < sb.size() && sb[i].due <= due) i++;
        sb.insert(i, it);
    endtask

    // monitor: pops items that fall due, between clock edges
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            int act;
            it = sb.pop_front();
            act = it.is_mute ? int'(mute) : int'(state);
            if (it.due < cyc) check(1'b0, {it.tag, " (missed)"}, act, it.val);
            else              check(act == int'(it.val), it.tag, act, it.val);
        end
    end

    task automatic strobe_on(input int target);
        forever begin
            @(negedge clk);
            if (cyc + 1 == target) break;
        end
        line_stb = 1'b1;
        last_edge = target;
        @(negedge clk);
        line_stb = 1'b0;
    endtask

    task automatic prime();
        strobe_on(cyc + 3);
    endtask

    task automatic gap(input int p, output int e);
        strobe_on(last_edge + p);
        e = last_edge;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    initial begin
        int e, l, b, c;
        repeat (4) @(negedge clk);
        check(state == 2'd0, "R1 state in reset", state, 0);
        check(mute == 1'b1, "R1 mute in reset", mute, 1);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check(state == 2'd0, "R1 state after reset", state, 0);
        check(mute == 1'b1, "R1 mute after reset", mute, 1);

        // lock from reset using both window boundaries (R2, R5, R9)
        prime();
        gap(PMIN, e);
        gap(PMAX, e);
        for (int i = 0; i < 5; i++) gap(64, e);
        expect_at(e + 1, 0, 0, "R5 seven lines stay MUTED");
        gap(64, e);
        expect_at(e + 1, 0, 1, "R2 R5 eighth line locks VALID");
        expect_at(e + 1, 1, 1, "R9 mute lags state");
        expect_at(e + 2, 1, 0, "R9 mute released");

        // silence -> probation -> expiry (R3, R6, R8, R9)
        l = e;
        expect_at(l + PMAX, 0, 1, "R3 still VALID before timeout");
        expect_at(l + PMAX + 1, 0, 2, "R3 R6 silence enters PROBATION");
        expect_at(l + PMAX + 2, 1, 0, "R6 mute low in probation");
        expect_at(l + PMAX + PROB, 0, 2, "R8 still PROBATION before expiry");
        expect_at(l + PMAX + PROB, 1, 0, "R6 mute low late in probation");
        expect_at(l + PMAX + 1 + PROB, 0, 0, "R8 expiry to MUTED");
        expect_at(l + PMAX + 2 + PROB, 1, 1, "R8 R9 mute asserted");
        wait_until(l + PMAX + PROB + 10);

        // relock after mute, then short gap and recovery in probation (R5, R3, R7)
        prime();
        for (int i = 0; i < 8; i++) gap(64, e);
        expect_at(e + 1, 0, 1, "R5 relock after mute");
        gap(PMIN - 1, b);
        expect_at(b + 1, 0, 2, "R3 short gap enters PROBATION");
        expect_at(b + 300, 1, 0, "R7 mute low during recovery");
        for (int i = 0; i < 7; i++) gap(64, e);
        expect_at(e + 1, 0, 2, "R7 seven lines stay PROBATION");
        gap(64, e);
        expect_at(e + 1, 0, 1, "R7 recovery to VALID");
        expect_at(e + 2, 1, 0, "R7 mute never rose");

        // partial recovery then expiry (R8)
        gap(40, c);
        expect_at(c + 1, 0, 2, "R3 gap 40 enters PROBATION");
        for (int i = 0; i < 5; i++) gap(64, e);
        expect_at(c + PROB, 0, 2, "R8 partial run keeps PROBATION");
        expect_at(c + 1 + PROB, 0, 0, "R8 expiry after partial run");
        expect_at(c + 2 + PROB, 1, 1, "R8 mute after partial run");
        wait_until(c + PROB + 10);

        // interrupted run while muted (R4)
        prime();
        for (int i = 0; i < 7; i++) gap(64, e);
        expect_at(e + 1, 0, 0, "R4 seven lines stay MUTED");
        gap(45, e);
        expect_at(e + 1, 0, 0, "R4 short gap keeps MUTED");
        for (int i = 0; i < 7; i++) gap(64, e);
        expect_at(e + 1, 0, 0, "R4 run restarted after invalid line");
        gap(64, e);
        expect_at(e + 1, 0, 1, "R4 eight fresh lines lock");
        expect_at(e + 2, 1, 0, "R4 mute released");
        wait_until(e + 10);

        if (sb.size() != 0) check(1'b0, "scoreboard left items", sb.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100_000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule